// File: doc/BRIEF.md
# Mode-Dependent Interrupt Recognition Unit

This block sits next to the instruction sequencer of a small 8-bit processor core and decides, once per instruction, what the sequencer does next. It takes five raw request pins (processor reset, halt, non-maskable interrupt, fast interrupt and normal interrupt) and passes each one through a synchronizer. It gates the two maskable requests with their mask bits, turns the non-maskable pin into an edge-triggered pending flag, and at the instruction boundary chooses between fetching the next opcode, entering the halted state, or starting an interrupt entry.

A mode input sets how long a request must have been seen before it can be taken. In compatibility mode, a request seen for the first time in the last cycle of an instruction is held over and taken only at the boundary after the following instruction. In native mode the same request is taken at once, so a non-maskable pulse can single-step one-cycle instructions. When the core leaves the halted state, or a wait state (interrupt synchronise, or clear-mask-and-wait), the block flags one dead bus cycle so that the program counter can be reloaded before it is driven out.

Top module: `intr_recog`

## Requirements
- R1: Each request pin passes through two synchronizing flip-flops. A pin that rises one cycle before a boundary edge is not taken at that boundary, even in native mode.
- R2: When several requests are taken together the priority is, from highest: reset, halt, non-maskable, fast, normal.
- R3: `svc_req` is one-hot or zero and lasts one cycle per decision. Bit 3 is reset, bit 2 is non-maskable, bit 1 is fast and bit 0 is normal.
- R4: In compatibility mode (`native_mode`=0), a request must be visible in the synchronized, gated form for the boundary cycle and the cycle before it. A request that first becomes visible in the boundary cycle is taken at the next boundary.
- R5: In native mode (`native_mode`=1), a request that is visible in the boundary cycle is taken at that boundary.
- R6: The non-maskable request is taken on a rising edge of the synchronized pin. It stays pending until it is serviced and is serviced once per edge, however long the pin stays high.
- R7: The fast and normal requests are level-sensitive. They are blocked while `mask_firq` or `mask_irq`, respectively, is 1.
- R8: A halt taken at a boundary sets `halt_grant` in the next cycle. It stays set while the synchronized halt pin stays high, and no interrupt service is issued while it is set.
- R9: When the synchronized halt pin falls while `halt_grant` is set, `halt_grant` clears and `dead_cycle` is 1 for exactly that cycle.
- R10: A falling edge on `wait_state` gives `dead_cycle` = 1 in the following cycle only.
- R11: While halted, a reset request is taken without waiting for `instr_last`. It issues `svc_req` bit 3 and clears `halt_grant` in the same cycle, with no dead cycle.
- R12: While `rst_n` is low, `svc_req`, `halt_grant` and `dead_cycle` are all 0.
- R13: Outside the halted state, a service or halt decision is made only on a clock edge at which `instr_last` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset of this block |
| pin_reset | input | 1 | Raw processor reset request, active high |
| pin_halt | input | 1 | Raw halt request, active high |
| pin_nmi | input | 1 | Raw non-maskable request, rising-edge sensitive |
| pin_firq | input | 1 | Raw fast interrupt request, level, active high |
| pin_irq | input | 1 | Raw normal interrupt request, level, active high |
| instr_last | input | 1 | High in the last cycle of every instruction |
| mask_firq | input | 1 | Blocks the fast request when 1 |
| mask_irq | input | 1 | Blocks the normal request when 1 |
| native_mode | input | 1 | 1 = native (no recognition delay), 0 = compatibility |
| wait_state | input | 1 | High while the sequencer sits in a synchronise or clear-and-wait state |
| svc_req | output | 4 | One-hot service request: {reset, nmi, firq, irq} |
| halt_grant | output | 1 | Core is halted |
| dead_cycle | output | 1 | Insert one dead bus cycle now |

## Verification
The assertions assume that `native_mode` changes only while no request is visible. They also assume that `wait_state` is low during reset and never falls in the cycle in which halt is released, so that the two dead-cycle causes never meet. The bench changes the mode only between cases, after all pins have been low for several cycles. It drives `wait_state` only in its own scenario while halt is idle, and it raises `instr_last` only as single-cycle strobes at points it has chosen.

// File: rtl/intr_recog_pkg.sv
package intr_recog_pkg;

  localparam int NSRC     = 5;
  localparam int SRC_IRQ  = 0;
  localparam int SRC_FIRQ = 1;
  localparam int SRC_NMI  = 2;
  localparam int SRC_HALT = 3;
  localparam int SRC_RST  = 4;
  localparam int NSVC     = 4;

  typedef logic [NSRC-1:0] src_vec_t;
  typedef logic [NSVC-1:0] svc_vec_t;

  // Highest index wins; result is one-hot or zero.
  function automatic src_vec_t pick_highest(input src_vec_t v);
    src_vec_t r;
    logic     found;
    r     = '0;
    found = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i] && !found) begin
        r[i]  = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  // Map a winner vector to the sequencer service code (halt excluded).
  function automatic svc_vec_t to_svc(input src_vec_t w);
    return {w[SRC_RST], w[SRC_NMI], w[SRC_FIRQ], w[SRC_IRQ]};
  endfunction

endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/intr_eligibility.sv
module intr_eligibility
  import intr_recog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t sync_req,
  input  logic     mask_firq,
  input  logic     mask_irq,
  input  logic     native_mode,
  input  logic     nmi_taken,
  output src_vec_t gated,
  output src_vec_t visible,
  output logic     nmi_edge
);

  logic     nmi_prev_q;
  logic     nmi_pend_q;
  src_vec_t elig_q;

  assign nmi_edge = sync_req[SRC_NMI] & ~nmi_prev_q;

  always_comb begin
    gated           = '0;
    gated[SRC_RST]  = sync_req[SRC_RST];
    gated[SRC_HALT] = sync_req[SRC_HALT];
    gated[SRC_NMI]  = nmi_pend_q | nmi_edge;
    gated[SRC_FIRQ] = sync_req[SRC_FIRQ] & ~mask_firq;
    gated[SRC_IRQ]  = sync_req[SRC_IRQ] & ~mask_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
      elig_q     <= '0;
    end else begin
      nmi_prev_q <= sync_req[SRC_NMI];
      nmi_pend_q <= (nmi_pend_q | nmi_edge) & ~nmi_taken;
      elig_q     <= gated;
    end
  end

  assign visible = native_mode ? gated : (gated & elig_q);

endmodule

// File: rtl/intr_boundary_arb.sv
module intr_boundary_arb
  import intr_recog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t gated,
  input  src_vec_t visible,
  input  logic     instr_last,
  input  logic     wait_state,
  output src_vec_t win,
  output svc_vec_t svc_req,
  output logic     halt_grant,
  output logic     dead_cycle
);

  logic     halt_q;
  logic     wait_q;
  src_vec_t cand;
  logic     halt_d;
  logic     release_w;
  logic     wait_exit_w;

  always_comb begin
    cand = '0;
    if (halt_q)          cand[SRC_RST] = visible[SRC_RST];
    else if (instr_last) cand = visible;
  end

  assign win = pick_highest(cand);

  always_comb begin
    if (win[SRC_RST])  halt_d = 1'b0;
    else if (halt_q)   halt_d = gated[SRC_HALT];
    else               halt_d = win[SRC_HALT];
  end

  assign release_w   = halt_q & ~gated[SRC_HALT] & ~win[SRC_RST];
  assign wait_exit_w = wait_q & ~wait_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q     <= 1'b0;
      wait_q     <= 1'b0;
      svc_req    <= '0;
      dead_cycle <= 1'b0;
    end else begin
      halt_q     <= halt_d;
      wait_q     <= wait_state;
      svc_req    <= to_svc(win);
      dead_cycle <= release_w | wait_exit_w;
    end
  end

  assign halt_grant = halt_q;

endmodule

// File: rtl/intr_recog.sv
module intr_recog
  import intr_recog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_reset,
  input  logic       pin_halt,
  input  logic       pin_nmi,
  input  logic       pin_firq,
  input  logic       pin_irq,
  input  logic       instr_last,
  input  logic       mask_firq,
  input  logic       mask_irq,
  input  logic       native_mode,
  input  logic       wait_state,
  output logic [3:0] svc_req,
  output logic       halt_grant,
  output logic       dead_cycle
);

  src_vec_t raw_req;
  src_vec_t sync_req;
  src_vec_t gated_w;
  src_vec_t visible_w;
  src_vec_t win_w;
  logic     nmi_edge_w;
  svc_vec_t svc_w;

  assign raw_req = {pin_reset, pin_halt, pin_nmi, pin_firq, pin_irq};

  intr_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_req),
    .q     (sync_req)
  );

  intr_eligibility u_elig (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_req    (sync_req),
    .mask_firq   (mask_firq),
    .mask_irq    (mask_irq),
    .native_mode (native_mode),
    .nmi_taken   (win_w[SRC_NMI]),
    .gated       (gated_w),
    .visible     (visible_w),
    .nmi_edge    (nmi_edge_w)
  );

  intr_boundary_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .gated      (gated_w),
    .visible    (visible_w),
    .instr_last (instr_last),
    .wait_state (wait_state),
    .win        (win_w),
    .svc_req    (svc_w),
    .halt_grant (halt_grant),
    .dead_cycle (dead_cycle)
  );

  assign svc_req = svc_w;

endmodule

// File: rtl/intr_recog_chk.sv
module intr_recog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       native_mode,
  input logic       instr_last,
  input logic       wait_state,
  input logic [3:0] svc_req,
  input logic       halt_grant,
  input logic       dead_cycle,
  input logic [4:0] gated
);

  assert_onehot_svc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_req));

  assert_boundary_only_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc_req[2:0]) |-> $past(instr_last));

  assert_no_svc_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc_req[2:0]) |-> (!halt_grant && !$past(halt_grant)));

  assert_compat_irq_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(native_mode) && svc_req[0]) |-> $past(gated[0], 2));

  assert_compat_firq_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(native_mode) && svc_req[1]) |-> $past(gated[1], 2));

  assert_compat_nmi_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(native_mode) && svc_req[2]) |-> $past(gated[2], 2));

  assert_nmi_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req[2] |=> !svc_req[2]);

  assert_release_dead_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(halt_grant) && !svc_req[3]) |-> dead_cycle);

  assert_wait_dead_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_state) |=> dead_cycle);

endmodule

bind intr_recog intr_recog_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .native_mode (native_mode),
  .instr_last  (instr_last),
  .wait_state  (wait_state),
  .svc_req     (svc_req),
  .halt_grant  (halt_grant),
  .dead_cycle  (dead_cycle),
  .gated       (gated_w)
);

// File: tb/tb_intr_recog.sv
`timescale 1ns/1ps
module tb_intr_recog;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin_reset, pin_halt, pin_nmi, pin_firq, pin_irq;
  logic       instr_last, mask_firq, mask_irq, native_mode, wait_state;
  logic [3:0] svc_req;
  logic       halt_grant, dead_cycle;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  intr_recog dut (
    .clk(clk), .rst_n(rst_n),
    .pin_reset(pin_reset), .pin_halt(pin_halt), .pin_nmi(pin_nmi),
    .pin_firq(pin_firq), .pin_irq(pin_irq),
    .instr_last(instr_last), .mask_firq(mask_firq), .mask_irq(mask_irq),
    .native_mode(native_mode), .wait_state(wait_state),
    .svc_req(svc_req), .halt_grant(halt_grant), .dead_cycle(dead_cycle)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Raise a single-cycle boundary strobe; the decision lands on the next edge.
  task automatic boundary();
    instr_last = 1'b1;
    tick();
    instr_last = 1'b0;
  endtask

  task automatic idle_pins();
    pin_reset = 0; pin_halt = 0; pin_nmi = 0; pin_firq = 0; pin_irq = 0;
    tick(5);
  endtask

  // src: 0 irq, 1 firq, 2 nmi; lead: cycles the request is visible before the boundary cycle
  task automatic sweep_case(input bit native, input int src, input int lead);
    logic [3:0] bitv;
    bit         now;
    native_mode = native;
    bitv = 4'b0001 << src;
    now  = native || (lead >= 1);
    case (src)
      0: pin_irq  = 1'b1;
      1: pin_firq = 1'b1;
      default: pin_nmi = 1'b1;
    endcase
    tick(2 + lead);
    boundary();
    chk(native ? "R5 first boundary" : "R4 first boundary", svc_req, now ? bitv : 4'b0000);
    if (now) begin pin_irq = 0; pin_firq = 0; pin_nmi = 0; end
    tick(2);
    boundary();
    chk(native ? "R5 second boundary" : "R4 second boundary", svc_req, now ? 4'b0000 : bitv);
    idle_pins();
  endtask

  initial begin
    rst_n = 0;
    pin_reset = 0; pin_halt = 0; pin_nmi = 0; pin_firq = 0; pin_irq = 0;
    instr_last = 0; mask_firq = 0; mask_irq = 0; native_mode = 0; wait_state = 0;
    pin_irq = 1; pin_halt = 1; instr_last = 1;
    tick(4);
    chk("R12 svc in reset", svc_req, 4'b0000);
    chk("R12 halt in reset", {3'b0, halt_grant}, 4'b0000);
    chk("R12 dead in reset", {3'b0, dead_cycle}, 4'b0000);
    pin_irq = 0; pin_halt = 0; instr_last = 0;
    rst_n = 1;
    tick(3);

    // R4 / R5 sweep over mode, source and lead time
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 3; s++)
        for (int l = 0; l < 3; l++)
          sweep_case(m[0], s, l);

    // R1: pin raised one cycle before the boundary edge is not yet visible
    native_mode = 1;
    pin_irq = 1;
    tick();
    boundary();
    chk("R1 sync latency", svc_req, 4'b0000);
    idle_pins();

    // R13: visible request with no boundary strobe
    pin_firq = 1;
    tick(6);
    chk("R13 no strobe no service", svc_req, 4'b0000);
    idle_pins();

    // R2 / R6 / R7: priority, nmi once per edge, masks
    pin_nmi = 1; pin_firq = 1; pin_irq = 1;
    tick(3);
    boundary();
    chk("R2 nmi over firq/irq", svc_req, 4'b0100);
    tick();
    chk("R3 single-cycle pulse", svc_req, 4'b0000);
    boundary();
    chk("R6 nmi held high not repeated, R2 firq next", svc_req, 4'b0010);
    mask_firq = 1;
    boundary();
    chk("R7 firq masked, irq taken", svc_req, 4'b0001);
    mask_irq = 1;
    boundary();
    chk("R7 both masked", svc_req, 4'b0000);
    mask_firq = 0; mask_irq = 0;
    idle_pins();

    // R8 / R2: halt beats interrupts, holds, blocks service
    pin_halt = 1; pin_irq = 1; pin_nmi = 1;
    tick(3);
    boundary();
    chk("R8 halt grant", {3'b0, halt_grant}, 4'b0001);
    chk("R2 halt over nmi", svc_req, 4'b0000);
    tick(2);
    boundary();
    chk("R8 no service while halted", svc_req, 4'b0000);
    chk("R8 halt held", {3'b0, halt_grant}, 4'b0001);

    // R11: reset while halted, no strobe
    pin_reset = 1;
    tick(3);
    chk("R11 reset taken while halted", svc_req, 4'b1000);
    chk("R11 halt cleared", {3'b0, halt_grant}, 4'b0000);
    chk("R11 no dead cycle", {3'b0, dead_cycle}, 4'b0000);
    idle_pins();

    // R9: dead cycle on halt release
    pin_halt = 1;
    tick(3);
    boundary();
    chk("R9 halted", {3'b0, halt_grant}, 4'b0001);
    tick(2);
    pin_halt = 0;
    tick(2);
    chk("R9 grant held during sync", {3'b0, halt_grant}, 4'b0001);
    tick();
    chk("R9 grant released", {3'b0, halt_grant}, 4'b0000);
    chk("R9 dead cycle", {3'b0, dead_cycle}, 4'b0001);
    tick();
    chk("R9 dead cycle one only", {3'b0, dead_cycle}, 4'b0000);
    idle_pins();

    // R10: dead cycle on wait exit
    wait_state = 1;
    tick(3);
    chk("R10 no dead while waiting", {3'b0, dead_cycle}, 4'b0000);
    wait_state = 0;
    tick();
    chk("R10 dead after wait", {3'b0, dead_cycle}, 4'b0001);
    tick();
    chk("R10 dead one only", {3'b0, dead_cycle}, 4'b0000);

    // R2: reset outranks halt at a boundary
    native_mode = 0;
    pin_reset = 1; pin_halt = 1;
    tick(3);
    boundary();
    chk("R2 reset over halt", svc_req, 4'b1000);
    chk("R2 no halt grant", {3'b0, halt_grant}, 4'b0000);
    idle_pins();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule